// File: doc/BRIEF.md
# PLL Multiplier Shift-Register Code Converter

This block translates a PLL feedback multiplier between its plain binary value and the 17-bit code that the feedback divider loads. The code is a 15-bit shift-register state sequence: a multiplier M sits a fixed number of shift steps away from the seed state 0x4000. Two small multipliers have dedicated codes that lie outside the sequence. Converting in either direction means walking that sequence, so the block advances one step per clock rather than using a lookup table.

Alongside the conversion, the block derives the two loop-bandwidth fields that belong with the multiplier. One is a proportional setting and the other is an integral setting. The integral setting needs a small ceiling division, which a repeated-subtraction divider computes once the conversion has finished. A caller drives one start strobe with a mode bit and a data word. It then waits for the one-cycle done pulse. After that pulse all four results hold still until the next accepted start.

Top module: `pll_mcode_conv`

## Requirements
- R1: In encode mode (mode_i = 0, multiplier taken from data_i[15:0]), the multipliers 0, 1 and 2 produce code_o values of 0x00000, 0x18003 and 0x10003 respectively.
- R2: In encode mode, a multiplier M from 3 to 32768 starts from state 0x4000. The state takes one step for each value from M to 32768 inclusive, which is 32769-M steps. Each step sets the new bit 14 to old bit 0 XOR old bit 1 and shifts old bits 14:1 down into bits 13:0. For example, 32768 encodes to 0x02000.
- R3: In encode mode, a multiplier above 32768 takes zero steps and yields 0x04000. data_i[16] has no effect in encode mode. In encode mode mult_o echoes data_i[15:0].
- R4: In decode mode (mode_i = 1), the code 0x18003 yields mult_o = 1 and the code 0x10003 yields mult_o = 2. In decode mode code_o echoes data_i.
- R5: In decode mode, any other code is stepped backwards until the state equals 0x04000, and mult_o is 32769 minus the number of steps taken. Each backward step sets the new bit 0 to old bit 0 XOR old bit 14 and shifts old bits 13:0 up into bits 14:1, dropping everything above bit 14. The code 0x04000 decodes to 32769.
- R6: In decode mode, a code that does not reach 0x04000 within 32769 steps yields mult_o = 0, which marks it invalid.
- R7: selp_o is M/2+1 (integer division) for a multiplier M below 60, and 31 otherwise. M is mult_o.
- R8: seli_o depends on the multiplier M as follows: 1 if M > 16384; 2 if M > 8192; 4 if M > 2048; 8 if M >= 501; 4*ceil(1024/(M+9)) if M >= 60; otherwise (M AND 0x3C) + 4.
- R9: done_o is high for exactly one cycle per accepted start. mult_o, code_o, selp_o and seli_o are valid in that cycle and then stay unchanged until the next accepted start.
- R10: A start_i while busy_o is low is accepted, and busy_o is high from the next cycle until done_o. A start_i while busy_o is high is ignored.
- R11: After reset, busy_o and done_o are low and mult_o, code_o, selp_o and seli_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when busy_o is low |
| mode_i | input | 1 | 0 = encode multiplier to code, 1 = decode code to multiplier |
| data_i | input | 17 | Multiplier in bits 15:0 (encode) or code (decode) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| mult_o | output | 16 | Multiplier (echoed or decoded) |
| code_o | output | 17 | Code (encoded or echoed) |
| selp_o | output | 5 | Proportional bandwidth field |
| seli_o | output | 6 | Integral bandwidth field |

## Verification
The assertions assume that mode_i and data_i matter only in the cycle a start is accepted. They also assume that a caller which wants a result waits for done_o before issuing another start. The stimulus holds start_i for a single cycle and waits for the result, then idles a few cycles before the next operation. The one exception is a deliberate back-to-back strobe, which confirms that the second start is ignored. Multipliers are chosen at the edges of each bandwidth band and of the special codes. A few small multipliers that need tens of thousands of steps are included, so that the longest walks are covered.

// File: rtl/pll_mcode_pkg.sv
package pll_mcode_pkg;

  localparam int LFSR_W = 15;
  localparam int MULT_W = 16;
  localparam int CODE_W = LFSR_W + 2;
  localparam int CNT_W  = MULT_W;
  localparam int SELP_W = 5;
  localparam int SELI_W = 6;
  localparam int QUO_W  = 7;
  localparam int DIV_W  = MULT_W + 1;
  localparam int REM_W  = MULT_W + 2;

  localparam int MULT_TOP   = 1 << LFSR_W;
  localparam int STEP_LIMIT = MULT_TOP + 1;

  localparam logic [CODE_W-1:0] SEED     = CODE_W'(1 << (LFSR_W - 1));
  localparam logic [CODE_W-1:0] CODE_ONE = 17'h18003;
  localparam logic [CODE_W-1:0] CODE_TWO = 17'h10003;

  localparam int SELP_KNEE = 60;
  localparam int SELP_SAT  = 31;
  localparam int SELI_T1   = 16384;
  localparam int SELI_T2   = 8192;
  localparam int SELI_T4   = 2048;
  localparam int SELI_T8   = 501;
  localparam int SELI_MASK = 'h3C;
  localparam int DIV_NUM   = 1024;
  localparam int DIV_BIAS  = 9;

  typedef enum logic { OP_ENC = 1'b0, OP_DEC = 1'b1 } op_e;

  function automatic logic [CODE_W-1:0] fwd_step(input logic [CODE_W-1:0] x);
    logic [CODE_W-1:0] r;
    r = '0;
    r[LFSR_W-2:0] = x[LFSR_W-1:1];
    r[LFSR_W-1]   = x[0] ^ x[1];
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] bwd_step(input logic [CODE_W-1:0] x);
    logic [CODE_W-1:0] r;
    r = '0;
    r[LFSR_W-1:1] = x[LFSR_W-2:0];
    r[0]          = x[0] ^ x[LFSR_W-1];
    return r;
  endfunction

endpackage

// File: rtl/pll_mcode_lfsr.sv
module pll_mcode_lfsr
  import pll_mcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  op_e               op_i,
  input  logic [CODE_W-1:0] data_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [CODE_W-1:0] code_o
);

  op_e               op_q, op_n;
  logic              run_q, run_n, fin_q, fin_n;
  logic [CODE_W-1:0] st_q, st_n, cin_q, cin_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [MULT_W-1:0] mult_q, mult_n;
  logic [MULT_W-1:0] m_in;

  assign m_in = data_i[MULT_W-1:0];

  always_comb begin
    op_n   = op_q;
    run_n  = run_q;
    fin_n  = 1'b0;
    st_n   = st_q;
    cnt_n  = cnt_q;
    mult_n = mult_q;
    cin_n  = cin_q;
    if (load_i) begin
      op_n  = op_i;
      cin_n = data_i;
      if (op_i == OP_ENC) begin
        mult_n = m_in;
        if (m_in == '0) begin
          st_n = '0;  run_n = 1'b0; fin_n = 1'b1;
        end else if (m_in == MULT_W'(1)) begin
          st_n = CODE_ONE; run_n = 1'b0; fin_n = 1'b1;
        end else if (m_in == MULT_W'(2)) begin
          st_n = CODE_TWO; run_n = 1'b0; fin_n = 1'b1;
        end else begin
          st_n  = SEED;
          run_n = 1'b1;
          cnt_n = (m_in > MULT_W'(MULT_TOP)) ? '0 : (CNT_W'(STEP_LIMIT) - m_in);
        end
      end else begin
        if (data_i == CODE_ONE) begin
          mult_n = MULT_W'(1); run_n = 1'b0; fin_n = 1'b1;
        end else if (data_i == CODE_TWO) begin
          mult_n = MULT_W'(2); run_n = 1'b0; fin_n = 1'b1;
        end else begin
          st_n  = data_i;
          cnt_n = CNT_W'(STEP_LIMIT);
          run_n = 1'b1;
        end
      end
    end else if (run_q) begin
      if (op_q == OP_ENC) begin
        if (cnt_q == '0) begin
          run_n = 1'b0; fin_n = 1'b1;
        end else begin
          st_n  = fwd_step(st_q);
          cnt_n = cnt_q - 1'b1;
        end
      end else begin
        if (st_q == SEED || cnt_q == '0) begin
          mult_n = cnt_q; run_n = 1'b0; fin_n = 1'b1;
        end else begin
          st_n  = bwd_step(st_q);
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ENC;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      st_q   <= '0;
      cnt_q  <= '0;
      mult_q <= '0;
      cin_q  <= '0;
    end else begin
      op_q   <= op_n;
      run_q  <= run_n;
      fin_q  <= fin_n;
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      mult_q <= mult_n;
      cin_q  <= cin_n;
    end
  end

  assign busy_o = run_q;
  assign fin_o  = fin_q;
  assign mult_o = mult_q;
  assign code_o = (op_q == OP_DEC) ? cin_q : st_q;

endmodule

// File: rtl/pll_mcode_bw.sv
module pll_mcode_bw
  import pll_mcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [SELP_W-1:0] selp_o,
  output logic [SELI_W-1:0] seli_o
);

  logic [MULT_W-1:0]       m_q, m_n;
  logic [DIV_W-1:0]        d_q, d_n;
  logic signed [REM_W-1:0] rem_q, rem_n;
  logic [QUO_W-1:0]        q_q, q_n;
  logic                    run_q, run_n, fin_q, fin_n;
  logic [SELP_W-1:0]       selp_q, selp_n;
  logic [SELI_W-1:0]       seli_q, seli_n;

  always_comb begin
    m_n    = m_q;
    d_n    = d_q;
    rem_n  = rem_q;
    q_n    = q_q;
    run_n  = run_q;
    fin_n  = 1'b0;
    selp_n = selp_q;
    seli_n = seli_q;
    if (load_i) begin
      m_n   = mult_i;
      d_n   = {1'b0, mult_i} + DIV_W'(DIV_BIAS);
      rem_n = REM_W'(DIV_NUM);
      q_n   = '0;
      run_n = 1'b1;
    end else if (run_q) begin
      if (rem_q <= 0) begin
        run_n = 1'b0;
        fin_n = 1'b1;
        if (m_q < MULT_W'(SELP_KNEE)) selp_n = SELP_W'(m_q >> 1) + SELP_W'(1);
        else                          selp_n = SELP_W'(SELP_SAT);
        if      (m_q >  MULT_W'(SELI_T1))   seli_n = SELI_W'(1);
        else if (m_q >  MULT_W'(SELI_T2))   seli_n = SELI_W'(2);
        else if (m_q >  MULT_W'(SELI_T4))   seli_n = SELI_W'(4);
        else if (m_q >= MULT_W'(SELI_T8))   seli_n = SELI_W'(8);
        else if (m_q >= MULT_W'(SELP_KNEE)) seli_n = SELI_W'({q_q, 2'b00});
        else seli_n = SELI_W'(m_q & MULT_W'(SELI_MASK)) + SELI_W'(4);
      end else begin
        rem_n = rem_q - $signed({1'b0, d_q});
        q_n   = q_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q    <= '0;
      d_q    <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      selp_q <= '0;
      seli_q <= '0;
    end else begin
      m_q    <= m_n;
      d_q    <= d_n;
      rem_q  <= rem_n;
      q_q    <= q_n;
      run_q  <= run_n;
      fin_q  <= fin_n;
      selp_q <= selp_n;
      seli_q <= seli_n;
    end
  end

  assign busy_o = run_q;
  assign fin_o  = fin_q;
  assign selp_o = selp_q;
  assign seli_o = seli_q;

endmodule

// File: rtl/pll_mcode_conv.sv
module pll_mcode_conv
  import pll_mcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [CODE_W-1:0] code_o,
  output logic [SELP_W-1:0] selp_o,
  output logic [SELI_W-1:0] seli_o
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       core_busy, core_fin, bw_busy, bw_fin, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign busy_o = core_busy | core_fin | bw_busy;
  assign accept = start_i & ~busy_o;

  pll_mcode_lfsr u_lfsr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (accept),
    .op_i   (op_e'(mode_i)),
    .data_i (data_i),
    .busy_o (core_busy),
    .fin_o  (core_fin),
    .mult_o (mult_o),
    .code_o (code_o)
  );

  pll_mcode_bw u_bw (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (core_fin),
    .mult_i (mult_o),
    .busy_o (bw_busy),
    .fin_o  (bw_fin),
    .selp_o (selp_o),
    .seli_o (seli_o)
  );

  assign done_o = bw_fin;

endmodule

// File: rtl/pll_mcode_conv_chk.sv
module pll_mcode_conv_chk
  import pll_mcode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [MULT_W-1:0] mult_o,
  input logic [CODE_W-1:0] code_o,
  input logic [SELP_W-1:0] selp_o,
  input logic [SELI_W-1:0] seli_o
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable({mult_o, code_o, selp_o, seli_o})); // R9

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10

  AST_SELP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mult_o >= MULT_W'(SELP_KNEE)) |-> selp_o == SELP_W'(SELP_SAT)); // R7

  AST_SELI_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mult_o >= MULT_W'(SELI_T8)) |-> ($countones(seli_o) == 1 && seli_o <= SELI_W'(8))); // R8

endmodule

bind pll_mcode_conv pll_mcode_conv_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .mult_o  (mult_o),
  .code_o  (code_o),
  .selp_o  (selp_o),
  .seli_o  (seli_o)
);

// File: tb/tb_pll_mcode_conv.sv
`timescale 1ns/1ps
module tb_pll_mcode_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [16:0] data_i = '0;
  logic        busy_o, done_o;
  logic [15:0] mult_o;
  logic [16:0] code_o;
  logic [4:0]  selp_o;
  logic [5:0]  seli_o;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    int    mult;
    int    code;
    int    selp;
    int    seli;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  pll_mcode_conv dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .mult_o(mult_o), .code_o(code_o),
    .selp_o(selp_o), .seli_o(seli_o)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_enc(int m);
    int x;
    if (m == 0) return 0;
    if (m == 1) return 'h18003;
    if (m == 2) return 'h10003;
    x = 'h4000;
    for (int i = m; i <= 32768; i++) x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hffff);
    return x;
  endfunction

  function automatic int m_dec(int code);
    int x, i;
    if (code == 'h18003) return 1;
    if (code == 'h10003) return 2;
    x = code;
    i = 32769;
    while (x != 'h4000 && i > 0) begin
      x = ((x ^ (x >> 14)) & 1) | ((x << 1) & 'h7fff);
      i--;
    end
    return i;
  endfunction

  function automatic int m_selp(int m);
    return (m < 60) ? (m / 2 + 1) : 31;
  endfunction

  function automatic int m_seli(int m);
    int d;
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60) begin
      d = m + 9;
      return 4 * ((1024 + d - 1) / d);
    end
    return (m & 'h3C) + 4;
  endfunction

  function automatic exp_t model(string tag, bit mode, logic [16:0] data);
    exp_t e;
    e.tag = tag;
    if (!mode) begin
      e.mult = int'(data[15:0]);
      e.code = m_enc(e.mult);
    end else begin
      e.code = int'(data);
      e.mult = m_dec(e.code);
    end
    e.selp = m_selp(e.mult);
    e.seli = m_seli(e.mult);
    return e;
  endfunction

  task automatic run_op(string tag, bit mode, logic [16:0] data);
    sb.push_back(model(tag, mode, data));
    @(negedge clk);
    start_i = 1'b1; mode_i = mode; data_i = data;
    @(negedge clk);
    start_i = 1'b0;
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // R10: a second strobe one cycle later, while busy, must be ignored
  task automatic busy_ignore();
    sb.push_back(model("R10", 1'b0, 17'd32767));
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b0; data_i = 17'd32767;
    @(negedge clk);
    chk("R10", "busy after start", busy_o, 1);
    mode_i = 1'b0; data_i = 17'd0;
    @(negedge clk);
    start_i = 1'b0;
    wait (sb.size() == 0);
    repeat (40) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e, held;
    int hold_cnt = 0;
    bit prev_done = 0;
    forever begin
      @(negedge clk);
      if (done_o) begin
        if (prev_done) chk("R9", "done width", 2, 1);
        if (sb.size() == 0) begin
          chk("R10", "unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(e.tag, "mult", mult_o, e.mult);
          chk(e.tag, "code", code_o, e.code);
          chk("R7", "selp", selp_o, e.selp);
          chk("R8", "seli", seli_o, e.seli);
          held = e;
          hold_cnt = 2;
        end
      end else if (hold_cnt > 0) begin
        chk("R9", "held mult", mult_o, held.mult);
        chk("R9", "held code", code_o, held.code);
        chk("R9", "held seli", seli_o, held.seli);
        hold_cnt--;
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "busy", busy_o, 0);
    chk("R11", "done", done_o, 0);
    chk("R11", "outputs", {mult_o, code_o, selp_o, seli_o}, 0);

    run_op("R1", 1'b0, 17'd0);
    run_op("R1", 1'b0, 17'd1);
    run_op("R1", 1'b0, 17'd2);
    run_op("R2", 1'b0, 17'd32768);
    chk("R2", "32768 code literal", code_o, 'h02000);
    run_op("R2", 1'b0, 17'd32767);
    run_op("R3", 1'b0, 17'h18001);
    chk("R3", "above top literal", code_o, 'h04000);
    run_op("R3", 1'b0, 17'h18000);
    chk("R3", "bit16 ignored", code_o, 'h02000);
    run_op("R4", 1'b1, 17'h18003);
    run_op("R4", 1'b1, 17'h10003);
    run_op("R5", 1'b1, 17'h04000);
    chk("R5", "seed decodes", mult_o, 32769);
    run_op("R5", 1'b1, 17'h02000);
    run_op("R5", 1'b1, 17'(m_enc(32767)));
    chk("R5", "round trip", mult_o, 32767);
    busy_ignore();
    run_op("R2", 1'b0, 17'd16385);
    run_op("R2", 1'b0, 17'd16384);
    run_op("R2", 1'b0, 17'd501);
    run_op("R2", 1'b0, 17'd60);
    run_op("R2", 1'b0, 17'd59);
    run_op("R6", 1'b1, 17'h00000);
    chk("R6", "invalid gives zero", mult_o, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule